// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block maps a 13-bit virtual word address onto a 12-bit physical word address. The virtual space of 8K words is cut into eight pages of 1024 words, and the physical space of 4K words into four blocks of the same size. A small table with one entry per page records which physical block holds that page, and whether the page is resident at all.

Software or a management engine fills the table through a write port. Each write names a page and supplies a block number and a resident flag. Clients then present virtual addresses on a request port. One cycle later the block returns either a translated physical address with a valid strobe, or a one-cycle fault pulse carrying the number of the missing page. Bringing the missing page in and choosing a victim block are left to the surrounding system.

Top module: `vpage_xlate`

## Requirements
- R1: While reset is high and in the first cycle after it, rsp_valid and rsp_fault are 0. Reset marks every page non-resident, so a lookup of any page before it is written faults.
- R2: The page number is bits 12..10 of req_vaddr, and the line within the page is bits 9..0.
- R3: A request to a resident page gives rsp_valid = 1 and rsp_paddr = {block, line}. The block number sits in bits 11..10 and the line in bits 9..0.
- R4: A request to a non-resident page gives rsp_fault = 1 and rsp_valid = 0 for one cycle, with rsp_fault_page equal to the requested page.
- R5: Each result appears in the cycle after the clock edge that samples req_valid. When req_valid was low at that edge, rsp_valid and rsp_fault are both 0.
- R6: A table write stores the block number and the resident flag for the named page. A write with the flag 0 takes the page out of residence.
- R7: When a write and a lookup of the same page share a clock edge, the lookup uses the entry as it stood before the write. The new entry applies from the next request on.
- R8: rsp_paddr is 0 whenever rsp_valid is 0, and rsp_fault_page is 0 whenever rsp_fault is 0.
- R9: With pages 1, 2, 5 and 6 loaded into blocks 3, 0, 1 and 2 and all other pages absent, every one of the 8192 virtual addresses translates or faults to match that table.
- R10: Requests on consecutive cycles each produce their own result on consecutive cycles, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tbl_we | input | 1 | Table write strobe |
| tbl_page | input | 3 | Page whose entry is written |
| tbl_block | input | 2 | Physical block number to store |
| tbl_present | input | 1 | Resident flag to store |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 13 | Virtual word address |
| rsp_valid | output | 1 | Translation succeeded |
| rsp_paddr | output | 12 | Physical word address, 0 when not valid |
| rsp_fault | output | 1 | Page fault pulse |
| rsp_fault_page | output | 3 | Faulting page number, 0 when no fault |

## Verification
Every response is due exactly one clock edge after the edge that samples its request. The table read and the request qualifiers are each one register deep, so no other stage delays the result. The bench drives each request on a falling edge, lets one rising edge pass, and compares all four outputs on the following falling edge against a bench-side copy of the table. That copy is updated only after the expected value has been formed, so a write in the same cycle does not affect the lookup it shares that edge with. Idle cycles are checked the same way to confirm that both strobes and both data outputs return to zero.

// File: rtl/vat_pkg.sv
package vat_pkg;

  localparam int unsigned DEF_PAGE_W = 3;
  localparam int unsigned DEF_LINE_W = 10;
  localparam int unsigned DEF_BLK_W  = 2;

  typedef enum logic [1:0] {
    RSP_IDLE  = 2'd0,
    RSP_HIT   = 2'd1,
    RSP_FAULT = 2'd2
  } rsp_kind_e;

endpackage

// File: rtl/vat_split.sv
module vat_split #(
  parameter int unsigned PAGE_W = vat_pkg::DEF_PAGE_W,
  parameter int unsigned LINE_W = vat_pkg::DEF_LINE_W,
  localparam int unsigned VA_W  = PAGE_W + LINE_W
) (
  input  logic [VA_W-1:0]   vaddr,
  output logic [PAGE_W-1:0] page,
  output logic [LINE_W-1:0] line
);

  always_comb begin
    page = vaddr[VA_W-1:LINE_W];
    line = vaddr[LINE_W-1:0];
  end

endmodule

// File: rtl/vat_table.sv
module vat_table #(
  parameter int unsigned PAGE_W = vat_pkg::DEF_PAGE_W,
  parameter int unsigned BLK_W  = vat_pkg::DEF_BLK_W,
  localparam int unsigned NPAGES = 1 << PAGE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_page,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic              wr_pres,
  input  logic              rd_en,
  input  logic [PAGE_W-1:0] rd_page,
  output logic [BLK_W-1:0]  rd_blk,
  output logic              rd_pres
);

  // Block numbers: plain array with a registered read, no reset.
  logic [BLK_W-1:0] blk_mem [NPAGES];
  logic [NPAGES-1:0] pres_vec;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      blk_mem[wr_page] <= wr_blk;
    end
    if (rd_en) begin
      rd_blk <= blk_mem[rd_page];
    end
  end

  // Resident flags: one flop per page so reset can clear them all.
  for (genvar g = 0; g < NPAGES; g++) begin : g_pres
    always_ff @(posedge clk) begin
      if (rst) begin
        pres_vec[g] <= 1'b0;
      end else if (wr_en && (wr_page == PAGE_W'(g))) begin
        pres_vec[g] <= wr_pres;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pres <= 1'b0;
    end else if (rd_en) begin
      rd_pres <= pres_vec[rd_page];
    end
  end

endmodule

// File: rtl/vat_resp.sv
module vat_resp #(
  parameter int unsigned PAGE_W = vat_pkg::DEF_PAGE_W,
  parameter int unsigned LINE_W = vat_pkg::DEF_LINE_W,
  parameter int unsigned BLK_W  = vat_pkg::DEF_BLK_W,
  localparam int unsigned PA_W  = BLK_W + LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [PAGE_W-1:0] page,
  input  logic [LINE_W-1:0] line,
  input  logic [BLK_W-1:0]  rd_blk,
  input  logic              rd_pres,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_fault,
  output logic [PAGE_W-1:0] rsp_fault_page
);
  import vat_pkg::*;

  logic              req_q;
  logic [PAGE_W-1:0] page_q;
  logic [LINE_W-1:0] line_q;
  rsp_kind_e         kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      page_q <= '0;
      line_q <= '0;
    end else begin
      req_q <= req;
      if (req) begin
        page_q <= page;
        line_q <= line;
      end
    end
  end

  always_comb begin
    if (!req_q) begin
      kind = RSP_IDLE;
    end else if (rd_pres) begin
      kind = RSP_HIT;
    end else begin
      kind = RSP_FAULT;
    end
  end

  always_comb begin
    rsp_valid      = (kind == RSP_HIT);
    rsp_fault      = (kind == RSP_FAULT);
    rsp_paddr      = rsp_valid ? {rd_blk, line_q} : '0;
    rsp_fault_page = rsp_fault ? page_q : '0;
  end

endmodule

// File: rtl/vpage_xlate.sv
module vpage_xlate #(
  parameter int unsigned PAGE_W = vat_pkg::DEF_PAGE_W,
  parameter int unsigned LINE_W = vat_pkg::DEF_LINE_W,
  parameter int unsigned BLK_W  = vat_pkg::DEF_BLK_W,
  localparam int unsigned VA_W  = PAGE_W + LINE_W,
  localparam int unsigned PA_W  = BLK_W + LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tbl_we,
  input  logic [PAGE_W-1:0] tbl_page,
  input  logic [BLK_W-1:0]  tbl_block,
  input  logic              tbl_present,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_fault,
  output logic [PAGE_W-1:0] rsp_fault_page
);

  logic [PAGE_W-1:0] req_page;
  logic [LINE_W-1:0] req_line;
  logic [BLK_W-1:0]  rd_blk;
  logic              rd_pres;

  vat_split #(.PAGE_W(PAGE_W), .LINE_W(LINE_W)) u_split (
    .vaddr (req_vaddr),
    .page  (req_page),
    .line  (req_line)
  );

  vat_table #(.PAGE_W(PAGE_W), .BLK_W(BLK_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tbl_we),
    .wr_page (tbl_page),
    .wr_blk  (tbl_block),
    .wr_pres (tbl_present),
    .rd_en   (req_valid),
    .rd_page (req_page),
    .rd_blk  (rd_blk),
    .rd_pres (rd_pres)
  );

  vat_resp #(.PAGE_W(PAGE_W), .LINE_W(LINE_W), .BLK_W(BLK_W)) u_resp (
    .clk            (clk),
    .rst            (rst),
    .req            (req_valid),
    .page           (req_page),
    .line           (req_line),
    .rd_blk         (rd_blk),
    .rd_pres        (rd_pres),
    .rsp_valid      (rsp_valid),
    .rsp_paddr      (rsp_paddr),
    .rsp_fault      (rsp_fault),
    .rsp_fault_page (rsp_fault_page)
  );

endmodule

// File: rtl/vat_chk.sv
module vat_chk #(
  parameter int unsigned PAGE_W = vat_pkg::DEF_PAGE_W,
  parameter int unsigned LINE_W = vat_pkg::DEF_LINE_W,
  parameter int unsigned BLK_W  = vat_pkg::DEF_BLK_W,
  localparam int unsigned VA_W  = PAGE_W + LINE_W,
  localparam int unsigned PA_W  = BLK_W + LINE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [VA_W-1:0]   req_vaddr,
  input logic              rsp_valid,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic              rsp_fault,
  input logic [PAGE_W-1:0] rsp_fault_page
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !rsp_fault));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_fault));

  // R10
  one_result_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_valid ^ rsp_fault));

  // R4
  fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_valid, rsp_fault}));

  // R3
  line_pass_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_valid ||
                   rsp_paddr[LINE_W-1:0] == $past(req_vaddr[LINE_W-1:0])));

  // R2
  fault_page_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_fault ||
                   rsp_fault_page == $past(req_vaddr[VA_W-1:LINE_W])));

  // R8
  quiet_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!rsp_valid |-> rsp_paddr == '0) and (!rsp_fault |-> rsp_fault_page == '0));

endmodule

bind vpage_xlate vat_chk #(.PAGE_W(PAGE_W), .LINE_W(LINE_W), .BLK_W(BLK_W)) u_vat_chk (
  .clk            (clk),
  .rst            (rst),
  .req_valid      (req_valid),
  .req_vaddr      (req_vaddr),
  .rsp_valid      (rsp_valid),
  .rsp_paddr      (rsp_paddr),
  .rsp_fault      (rsp_fault),
  .rsp_fault_page (rsp_fault_page)
);

// File: tb/test_vpage_xlate.sv
module test_vpage_xlate;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tbl_we = 1'b0;
  logic [2:0]  tbl_page = '0;
  logic [1:0]  tbl_block = '0;
  logic        tbl_present = 1'b0;
  logic        req_valid = 1'b0;
  logic [12:0] req_vaddr = '0;
  logic        rsp_valid;
  logic [11:0] rsp_paddr;
  logic        rsp_fault;
  logic [2:0]  rsp_fault_page;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [1:0] m_blk  [8];
  logic       m_pres [8];

  always #10 clk = ~clk;

  vpage_xlate i_vpage_xlate (
    .clk            (clk),
    .rst            (rst),
    .tbl_we         (tbl_we),
    .tbl_page       (tbl_page),
    .tbl_block      (tbl_block),
    .tbl_present    (tbl_present),
    .req_valid      (req_valid),
    .req_vaddr      (req_vaddr),
    .rsp_valid      (rsp_valid),
    .rsp_paddr      (rsp_paddr),
    .rsp_fault      (rsp_fault),
    .rsp_fault_page (rsp_fault_page)
  );

  task automatic compare(input string tag, input logic ev, input logic [11:0] epa,
                         input logic ef, input logic [2:0] efp);
    n_vec++;
    if (rsp_valid !== ev || rsp_paddr !== epa || rsp_fault !== ef || rsp_fault_page !== efp) begin
      n_fail++;
      $display("FAIL %s: got v=%0b pa=%h f=%0b fp=%0d, expected v=%0b pa=%h f=%0b fp=%0d",
               tag, rsp_valid, rsp_paddr, rsp_fault, rsp_fault_page, ev, epa, ef, efp);
    end
  endtask

  // Drive on a falling edge, one rising edge passes, compare on the next falling edge.
  task automatic step(input logic we, input logic [2:0] wp, input logic [1:0] wb,
                      input logic wpres, input logic rv, input logic [12:0] va,
                      input string tag);
    logic [2:0]  pg;
    logic        ev, ef;
    logic [11:0] epa;
    logic [2:0]  efp;
    tbl_we = we; tbl_page = wp; tbl_block = wb; tbl_present = wpres;
    req_valid = rv; req_vaddr = va;
    pg  = va[12:10];
    ev  = rv && m_pres[pg];
    ef  = rv && !m_pres[pg];
    epa = ev ? {m_blk[pg], va[9:0]} : 12'h000;
    efp = ef ? pg : 3'd0;
    if (we) begin
      m_blk[wp]  = wb;
      m_pres[wp] = wpres;
    end
    @(negedge clk);
    compare(tag, ev, epa, ef, efp);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 3'd0, 2'd0, 1'b0, 1'b0, 13'd0, tag);
  endtask

  task automatic wr(input logic [2:0] p, input logic [1:0] b, input logic pr);
    step(1'b1, p, b, pr, 1'b0, 13'd0, "R6");
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_blk[i]  = 2'd0;
      m_pres[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    compare("R1 in reset", 1'b0, 12'h000, 1'b0, 3'd0);
    rst = 1'b0;
    idle("R1 after reset");
    // R1: every page faults before any write
    for (int p = 0; p < 8; p++) begin
      step(1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 13'((p << 10) | (p * 37)), "R1 absent");
    end
    // R9: preload, then exhaustive sweep back to back (R10, R2, R3, R4)
    wr(3'd1, 2'd3, 1'b1);
    wr(3'd2, 2'd0, 1'b1);
    wr(3'd5, 2'd1, 1'b1);
    wr(3'd6, 2'd2, 1'b1);
    for (int a = 0; a < 8192; a++) begin
      step(1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 13'(a), "R9 sweep");
    end
    idle("R5 idle");
    idle("R5 idle");
    // R6: reprogram all pages with an arithmetic pattern, then sweep strided addresses
    for (int p = 0; p < 8; p++) begin
      wr(3'(p), 2'((3 * p + 1) % 4), 1'((p + 1) % 2 == 0 || p == 4));
    end
    for (int a = 0; a < 8192; a += 7) begin
      step(1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 13'(a), "R6 sweep");
    end
    // R6: invalidate page 1 then look it up
    wr(3'd1, 2'd2, 1'b0);
    step(1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 13'h07FF, "R6 invalidate");
    // R7: write and lookup of the same page on the same edge
    step(1'b1, 3'd1, 2'd3, 1'b1, 1'b1, 13'h0400, "R7 old entry");
    step(1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 13'h0401, "R7 new entry");
    step(1'b1, 3'd3, 2'd0, 1'b0, 1'b1, 13'h0C2A, "R7 old resident");
    step(1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 13'h0C2A, "R7 now absent");
    // R4/R8: fault followed by idle, alternating
    for (int k = 0; k < 16; k++) begin
      step(1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 13'((k % 8) * 1024 + 1023), "R4 alt");
      idle("R8 idle after");
    end
    // R1: reset again clears residency
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) m_pres[i] = 1'b0;
    idle("R1 reapply");
    step(1'b0, 3'd0, 2'd0, 1'b0, 1'b1, 13'h1400, "R1 cleared");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

endmodule